// File: doc/BRIEF.md
# I2C General-Call Decoder

This block sits on the slave side of an I2C target and watches the bytes of each transfer as the bit-level receiver completes them. Each completed byte arrives as a one-cycle strobe together with its value and its position in the transfer. The decoder treats a first byte of 0x00 or 0x01 as a general call. It then reads the byte that follows as a command, or as a master address, and returns an acknowledge decision for both bytes.

A first byte of 0x00 starts a software general call. Command 0x06 asks the interface to reset itself, and 0x04 is a plain announcement. A first byte of 0x01 starts a hardware general call, and its second byte is the address of the master that issued it. For each of these calls the decoder raises a sticky interrupt flag and records a two-bit identifier of the call type. The reset command also gives a one-cycle interface-reset pulse. Software clears the flag and the identifier with a write-one-to-clear pulse. Ordinary address matching, the data FIFOs and the bit shifter are outside this block.

Top module: `gencall_decoder`

## Requirements
- R1: With `gc_en` set, a byte at index 0 whose value is 0x00 or 0x01 receives `resp_vld`=1 and `resp_ack`=1.
- R2: With `gc_en` clear, or with any other value at index 0, that byte receives `resp_vld`=1 and `resp_ack`=0. No general call opens, so a following index-1 byte gets no response and changes no output.
- R3: Index 0 = 0x00 followed by index 1 = 0x06 is acknowledged. It sets `gc_irq`, sets `gc_id` to 1, and drives `if_reset` high for exactly one cycle.
- R4: Index 0 = 0x00 followed by index 1 = 0x04 is acknowledged. It sets `gc_irq` and sets `gc_id` to 2, with no `if_reset` pulse.
- R5: Index 0 = 0x00 followed by any other command byte is answered `resp_ack`=0. It leaves `gc_irq` and `gc_id` unchanged and gives no `if_reset`.
- R6: Index 0 = 0x01 followed by any byte stores that byte on `hw_addr`, sets `gc_irq` and sets `gc_id` to 3. The second byte's `resp_ack` equals `hwgc_en`. `hw_addr` changes on no other event.
- R7: The first byte of a general call on its own never sets `gc_irq`. The flag can only rise on the second byte.
- R8: `irq_clr` clears `gc_irq` and `gc_id` to 0 and keeps `hw_addr`. If a flag-setting second byte lands in the same cycle, the set wins.
- R9: Bytes at index 2 or above get no response and change no output. So does an index-1 byte that does not follow a general-call first byte.
- R10: The response to a byte strobed at clock edge k is visible after edge k and lasts one cycle. Status outputs update at the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_vld | input | 1 | One-cycle strobe: a byte was received |
| byte_data | input | 8 | Received byte value |
| byte_idx | input | IDX_W | Position of the byte within the transfer, 0 = first |
| gc_en | input | 1 | Enables acknowledging general calls |
| hwgc_en | input | 1 | Enables acknowledging the second byte of a hardware general call |
| irq_clr | input | 1 | Write-one-to-clear pulse for flag and identifier |
| resp_vld | output | 1 | An acknowledge decision is presented |
| resp_ack | output | 1 | 1 = acknowledge, 0 = not acknowledge |
| gc_irq | output | 1 | Sticky general-call interrupt flag |
| gc_id | output | 2 | Call type: 1 reset, 2 announce, 3 hardware, 0 none |
| if_reset | output | 1 | One-cycle interface-reset request |
| hw_addr | output | 8 | Master address captured from a hardware general call |

## Verification
The bench sends the two command codes, an unknown command, and hardware calls with the enable in both states. A design that mixes up the codes would report the wrong identifier or fire the reset on an announcement. A design that treats unknown commands as valid would acknowledge them or raise the flag. It also sends first bytes alone, stray index-1 bytes, bytes beyond index 1, and general calls while the enable is off. A decoder that forgets to close the call after the second byte, or opens one while disabled, answers bytes it should not. It also tries a clear in the same cycle as a new event, where the wrong priority would lose the interrupt.

// File: rtl/gc_pkg.sv
package gc_pkg;
   typedef enum logic [1:0] {
      GC_NONE = 2'd0,
      GC_SW   = 2'd1,
      GC_HW   = 2'd2
   } gc_kind_e;

   localparam logic [1:0] GCID_NONE     = 2'd0;
   localparam logic [1:0] GCID_RESET    = 2'd1;
   localparam logic [1:0] GCID_ANNOUNCE = 2'd2;
   localparam logic [1:0] GCID_HW       = 2'd3;
endpackage

// File: rtl/gc_classify.sv
module gc_classify
   import gc_pkg::*;
#(
   parameter int          DATA_W       = 8,
   parameter logic [7:0]  SW_CALL      = 8'h00,
   parameter logic [7:0]  HW_CALL      = 8'h01,
   parameter logic [7:0]  CMD_RESET    = 8'h06,
   parameter logic [7:0]  CMD_ANNOUNCE = 8'h04
) (
   input  logic [DATA_W-1:0] data,
   output gc_kind_e          addr_kind,
   output logic              is_reset,
   output logic              is_announce
);
   always_comb begin
      if (data == DATA_W'(SW_CALL))      addr_kind = GC_SW;
      else if (data == DATA_W'(HW_CALL)) addr_kind = GC_HW;
      else                               addr_kind = GC_NONE;
   end

   assign is_reset    = (data == DATA_W'(CMD_RESET));
   assign is_announce = (data == DATA_W'(CMD_ANNOUNCE));
endmodule

// File: rtl/gc_seq.sv
module gc_seq
   import gc_pkg::*;
#(
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             byte_vld,
   input  logic [IDX_W-1:0] byte_idx,
   input  gc_kind_e         addr_kind,
   input  logic             is_reset,
   input  logic             is_announce,
   input  logic             gc_en,
   input  logic             hwgc_en,
   output logic             rsp_vld_d,
   output logic             rsp_ack_d,
   output logic             ev_reset,
   output logic             ev_announce,
   output logic             ev_hw
);
   gc_kind_e pend_q;
   logic     first_byte;
   logic     second_byte;

   assign first_byte  = byte_vld && (byte_idx == IDX_W'(0));
   assign second_byte = byte_vld && (byte_idx == IDX_W'(1)) && (pend_q != GC_NONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pend_q <= GC_NONE;
      else if (first_byte)
         pend_q <= gc_en ? addr_kind : GC_NONE;
      else if (byte_vld)
         pend_q <= GC_NONE;
   end

   assign ev_reset    = second_byte && (pend_q == GC_SW) && is_reset;
   assign ev_announce = second_byte && (pend_q == GC_SW) && is_announce;
   assign ev_hw       = second_byte && (pend_q == GC_HW);

   assign rsp_vld_d = first_byte || second_byte;

   always_comb begin
      if (first_byte)
         rsp_ack_d = gc_en && (addr_kind != GC_NONE);
      else if (second_byte)
         rsp_ack_d = ev_reset || ev_announce || (ev_hw && hwgc_en);
      else
         rsp_ack_d = 1'b0;
   end
endmodule

// File: rtl/gc_status.sv
module gc_status
   import gc_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_reset,
   input  logic              ev_announce,
   input  logic              ev_hw,
   input  logic [DATA_W-1:0] data,
   input  logic              irq_clr,
   output logic              gc_irq,
   output logic [1:0]        gc_id,
   output logic              if_reset,
   output logic [DATA_W-1:0] hw_addr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gc_irq   <= 1'b0;
         gc_id    <= GCID_NONE;
         if_reset <= 1'b0;
         hw_addr  <= '0;
      end else begin
         if_reset <= ev_reset;
         if (ev_reset) begin
            gc_irq <= 1'b1;
            gc_id  <= GCID_RESET;
         end else if (ev_announce) begin
            gc_irq <= 1'b1;
            gc_id  <= GCID_ANNOUNCE;
         end else if (ev_hw) begin
            gc_irq  <= 1'b1;
            gc_id   <= GCID_HW;
            hw_addr <= data;
         end else if (irq_clr) begin
            gc_irq <= 1'b0;
            gc_id  <= GCID_NONE;
         end
      end
   end
endmodule

// File: rtl/gencall_decoder.sv
module gencall_decoder
   import gc_pkg::*;
#(
   parameter int         IDX_W        = 4,
   parameter int         RESP_PIPE    = 1,
   parameter logic [7:0] CMD_RESET    = 8'h06,
   parameter logic [7:0] CMD_ANNOUNCE = 8'h04
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             byte_vld,
   input  logic [7:0]       byte_data,
   input  logic [IDX_W-1:0] byte_idx,
   input  logic             gc_en,
   input  logic             hwgc_en,
   input  logic             irq_clr,
   output logic             resp_vld,
   output logic             resp_ack,
   output logic             gc_irq,
   output logic [1:0]       gc_id,
   output logic             if_reset,
   output logic [7:0]       hw_addr
);
   localparam int DATA_W = 8;

   if (IDX_W < 1) begin : g_bad_idx
      $error("gencall_decoder: IDX_W must be at least 1");
   end
   if (RESP_PIPE != 0 && RESP_PIPE != 1) begin : g_bad_pipe
      $error("gencall_decoder: RESP_PIPE must be 0 or 1");
   end
   if (CMD_RESET == CMD_ANNOUNCE) begin : g_bad_cmd
      $error("gencall_decoder: command codes must differ");
   end

   gc_kind_e addr_kind;
   logic     is_reset, is_announce;
   logic     rsp_vld_d, rsp_ack_d;
   logic     ev_reset, ev_announce, ev_hw;

   gc_classify #(
      .DATA_W(DATA_W), .CMD_RESET(CMD_RESET), .CMD_ANNOUNCE(CMD_ANNOUNCE)
   ) u_cls (
      .data(byte_data), .addr_kind(addr_kind),
      .is_reset(is_reset), .is_announce(is_announce)
   );

   gc_seq #(.IDX_W(IDX_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_idx(byte_idx),
      .addr_kind(addr_kind), .is_reset(is_reset), .is_announce(is_announce),
      .gc_en(gc_en), .hwgc_en(hwgc_en),
      .rsp_vld_d(rsp_vld_d), .rsp_ack_d(rsp_ack_d),
      .ev_reset(ev_reset), .ev_announce(ev_announce), .ev_hw(ev_hw)
   );

   gc_status #(.DATA_W(DATA_W)) u_st (
      .clk(clk), .rst_n(rst_n), .ev_reset(ev_reset), .ev_announce(ev_announce),
      .ev_hw(ev_hw), .data(byte_data), .irq_clr(irq_clr),
      .gc_irq(gc_irq), .gc_id(gc_id), .if_reset(if_reset), .hw_addr(hw_addr)
   );

   if (RESP_PIPE == 1) begin : g_resp_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            resp_vld <= 1'b0;
            resp_ack <= 1'b0;
         end else begin
            resp_vld <= rsp_vld_d;
            resp_ack <= rsp_ack_d;
         end
      end
   end else begin : g_resp_comb
      assign resp_vld = rsp_vld_d;
      assign resp_ack = rsp_ack_d;
   end
endmodule

// File: rtl/gc_decoder_chk.sv
module gc_decoder_chk #(
   parameter int IDX_W     = 4,
   parameter int RESP_PIPE = 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             byte_vld,
   input logic [IDX_W-1:0] byte_idx,
   input logic             gc_en,
   input logic             irq_clr,
   input logic             resp_vld,
   input logic             resp_ack,
   input logic             gc_irq,
   input logic [1:0]       gc_id,
   input logic             if_reset,
   input logic [7:0]       hw_addr
);
   a_r3_reset_sets_id: assert property (@(posedge clk) disable iff (!rst_n)
      if_reset |-> (gc_irq && gc_id == 2'd1));

   a_r3_reset_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      if_reset |=> !if_reset);

   a_r8_irq_tracks_id: assert property (@(posedge clk) disable iff (!rst_n)
      gc_irq == (gc_id != 2'd0));

   a_r7_irq_on_second: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gc_irq) |-> $past(byte_vld && byte_idx == IDX_W'(1)));

   a_r6_addr_only_hw: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(hw_addr) |-> (gc_id == 2'd3));

   a_r8_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
      $past(irq_clr && !byte_vld) |-> !gc_irq);

   if (RESP_PIPE == 1) begin : g_pipe_chk
      a_r10_first_answered: assert property (@(posedge clk) disable iff (!rst_n)
         $past(byte_vld && byte_idx == IDX_W'(0)) |-> resp_vld);

      a_r2_disabled_nack: assert property (@(posedge clk) disable iff (!rst_n)
         $past(byte_vld && byte_idx == IDX_W'(0) && !gc_en) |-> (resp_vld && !resp_ack));

      a_r9_no_late_resp: assert property (@(posedge clk) disable iff (!rst_n)
         $past(!byte_vld || byte_idx > IDX_W'(1)) |-> !resp_vld);
   end
endmodule

bind gencall_decoder gc_decoder_chk #(.IDX_W(IDX_W), .RESP_PIPE(RESP_PIPE)) u_chk (
   .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_idx(byte_idx),
   .gc_en(gc_en), .irq_clr(irq_clr), .resp_vld(resp_vld), .resp_ack(resp_ack),
   .gc_irq(gc_irq), .gc_id(gc_id), .if_reset(if_reset), .hw_addr(hw_addr)
);

// File: tb/sim_gencall_decoder.sv
`timescale 1ns/1ps
module sim_gencall_decoder;
   localparam int IDX_W = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             byte_vld = 1'b0;
   logic [7:0]       byte_data = 8'h00;
   logic [IDX_W-1:0] byte_idx = '0;
   logic             gc_en = 1'b1;
   logic             hwgc_en = 1'b1;
   logic             irq_clr = 1'b0;
   logic             resp_vld, resp_ack, gc_irq, if_reset;
   logic [1:0]       gc_id;
   logic [7:0]       hw_addr;

   int n_run = 0;
   int n_fail = 0;

   logic       s_vld, s_ack, s_irq, s_rst;
   logic [1:0] s_id;
   logic [7:0] s_addr;

   always #4 clk = ~clk;

   gencall_decoder #(.IDX_W(IDX_W)) u0 (
      .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_data(byte_data),
      .byte_idx(byte_idx), .gc_en(gc_en), .hwgc_en(hwgc_en), .irq_clr(irq_clr),
      .resp_vld(resp_vld), .resp_ack(resp_ack), .gc_irq(gc_irq), .gc_id(gc_id),
      .if_reset(if_reset), .hw_addr(hw_addr)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic grab();
      s_vld = resp_vld; s_ack = resp_ack; s_irq = gc_irq;
      s_rst = if_reset; s_id = gc_id; s_addr = hw_addr;
   endtask

   // strobe one byte, sample one step after the capturing edge
   task automatic send(input int idx, input logic [7:0] d, input logic clr = 1'b0);
      @(negedge clk);
      byte_vld = 1'b1; byte_idx = IDX_W'(idx); byte_data = d; irq_clr = clr;
      @(posedge clk); #1;
      grab();
      @(negedge clk);
      byte_vld = 1'b0; irq_clr = 1'b0;
   endtask

   task automatic next_cycle();
      @(posedge clk); #1;
      grab();
   endtask

   task automatic clear_flags();
      @(negedge clk); irq_clr = 1'b1;
      @(negedge clk); irq_clr = 1'b0;
   endtask

   task automatic t_reset_state();
      chk(resp_vld == 0, "R10", "resp_vld after reset", resp_vld, 0);
      chk(gc_irq == 0 && gc_id == 0, "R8", "irq/id after reset", {gc_irq, gc_id}, 0);
      chk(if_reset == 0 && hw_addr == 0, "R6", "rst/addr after reset", {if_reset, hw_addr}, 0);
   endtask

   task automatic t_reset_cmd();
      send(0, 8'h00);
      chk(s_vld && s_ack, "R1", "ack of 0x00", {s_vld, s_ack}, 3);
      chk(!s_irq, "R7", "irq after first byte only", s_irq, 0);
      next_cycle();
      chk(!s_vld, "R10", "resp lasts one cycle", s_vld, 0);
      send(1, 8'h06);
      chk(s_vld && s_ack, "R3", "ack of reset cmd", {s_vld, s_ack}, 3);
      chk(s_irq && s_id == 2'd1, "R3", "irq/id reset", {s_irq, s_id}, 5);
      chk(s_rst, "R3", "if_reset high", s_rst, 1);
      next_cycle();
      chk(!s_rst, "R3", "if_reset one cycle", s_rst, 0);
      clear_flags();
      #1 chk(!gc_irq && gc_id == 0, "R8", "cleared", {gc_irq, gc_id}, 0);
   endtask

   task automatic t_announce();
      send(0, 8'h00);
      send(1, 8'h04);
      chk(s_vld && s_ack, "R4", "ack of announce", {s_vld, s_ack}, 3);
      chk(s_irq && s_id == 2'd2, "R4", "irq/id announce", {s_irq, s_id}, 6);
      chk(!s_rst, "R4", "no if_reset", s_rst, 0);
   endtask

   task automatic t_other_cmd();
      // id is 2 from previous scenario; must stay
      send(0, 8'h00);
      send(1, 8'h05);
      chk(s_vld && !s_ack, "R5", "nack of unknown cmd", {s_vld, s_ack}, 2);
      chk(s_irq && s_id == 2'd2, "R5", "id unchanged", s_id, 2);
      chk(!s_rst, "R5", "no if_reset", s_rst, 0);
      clear_flags();
      send(0, 8'h00);
      send(1, 8'h07);
      chk(!s_irq && s_id == 0, "R5", "no irq from unknown", {s_irq, s_id}, 0);
   endtask

   task automatic t_hw_call();
      hwgc_en = 1'b1;
      send(0, 8'h01);
      chk(s_vld && s_ack, "R1", "ack of 0x01", {s_vld, s_ack}, 3);
      send(1, 8'hA6);
      chk(s_vld && s_ack, "R6", "ack with hw enable", {s_vld, s_ack}, 3);
      chk(s_irq && s_id == 2'd3, "R6", "irq/id hw", {s_irq, s_id}, 7);
      chk(s_addr == 8'hA6, "R6", "captured addr", s_addr, 8'hA6);
      clear_flags();
      #1 chk(hw_addr == 8'hA6, "R8", "addr kept over clear", hw_addr, 8'hA6);
      hwgc_en = 1'b0;
      send(0, 8'h01);
      send(1, 8'h3C);
      chk(s_vld && !s_ack, "R6", "nack with hw disabled", {s_vld, s_ack}, 2);
      chk(s_irq && s_id == 2'd3 && s_addr == 8'h3C, "R6", "capture with hw disabled",
          s_addr, 8'h3C);
      hwgc_en = 1'b1;
      clear_flags();
   endtask

   task automatic t_disabled();
      gc_en = 1'b0;
      send(0, 8'h00);
      chk(s_vld && !s_ack, "R2", "nack when disabled", {s_vld, s_ack}, 2);
      send(1, 8'h06);
      chk(!s_vld && !s_irq && !s_rst, "R2", "second byte ignored when disabled",
          {s_vld, s_irq, s_rst}, 0);
      gc_en = 1'b1;
      send(0, 8'h42);
      chk(s_vld && !s_ack, "R2", "nack of non-gc address", {s_vld, s_ack}, 2);
      send(1, 8'h04);
      chk(!s_vld && !s_irq && s_id == 0, "R2", "no call after non-gc", {s_vld, s_irq}, 0);
   endtask

   task automatic t_stray();
      send(1, 8'h06);
      chk(!s_vld && !s_irq && !s_rst, "R9", "stray index-1 byte", {s_vld, s_irq, s_rst}, 0);
      send(0, 8'h00);
      send(2, 8'h06);
      chk(!s_vld && !s_irq, "R9", "index-2 byte ignored", {s_vld, s_irq}, 0);
      send(1, 8'h06);
      chk(!s_vld && !s_irq, "R9", "call closed by index-2", {s_vld, s_irq}, 0);
      send(0, 8'h00);
      send(1, 8'h04);
      send(1, 8'h06);
      chk(!s_vld && s_id == 2'd2 && !s_rst, "R9", "second index-1 ignored", s_id, 2);
      clear_flags();
   endtask

   task automatic t_clear_race();
      send(0, 8'h00);
      send(1, 8'h04, 1'b1);
      chk(s_irq && s_id == 2'd2, "R8", "set wins over clear", {s_irq, s_id}, 6);
      clear_flags();
      #1 chk(!gc_irq && gc_id == 0, "R8", "clear after race", {gc_irq, gc_id}, 0);
   endtask

   initial begin : watchdog
      #1_000_000;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      @(posedge clk); #1;
      t_reset_state();
      t_reset_cmd();
      t_announce();
      t_other_cmd();
      t_hw_call();
      t_disabled();
      t_stray();
      t_clear_race();
      repeat (2) @(posedge clk);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule